// File: doc/BRIEF.md
# Global Two-Level Branch Direction Predictor

This block predicts the direction of conditional branches. It keeps one history shift register that all branches share and one table of small per-pattern state machines. The current history contents select the table entry. When a front end asks for a prediction, the block answers in the same cycle with a taken or not-taken decision and a copy of the history it used. In the next clock edge the block shifts its own guess into the history. It does not wait for the branch to resolve.

When the branch resolves, the back end returns three things: the real outcome, a flag saying whether the guess was wrong, and the history copy that came with the prediction. The block trains the table entry that the history copy selects. On a wrong guess it also rebuilds the history from that copy and the real outcome.

An elaboration-time parameter chooses the per-entry automaton. It can be a single last-outcome bit, a record of the last two outcomes, or a two-bit saturating counter.

Top module: `glob_dir_predictor`

## Requirements
- R1: After reset the history is all zeros. Every entry predicts taken: counter and two-outcome entries hold 3, and last-outcome entries hold 1.
- R2: A prediction request with no repair in the same cycle does two things. The history output shows the pre-request history during the request cycle. After the next edge, the history becomes the old history shifted left by one, with the predicted bit (1 = taken) entering at bit 0 and the top bit dropped.
- R3: A resolve with the mispredict flag set does not keep the speculative history. After the next edge, the history equals the returned snapshot shifted left by one, with the real outcome at bit 0.
- R4: When a repair and a prediction request arrive in the same cycle, the repair decides the next history and the speculative shift is dropped.
- R5: A resolve trains only the entry selected by the returned snapshot. Every other entry keeps its prediction.
- R6: With KIND=2, each entry is a 2-bit counter. It counts up on taken and down on not taken, holds at 3 and at 0, and predicts taken for values 2 and 3.
- R7: With KIND=0, each entry predicts the outcome last resolved against it.
- R8: With KIND=1, each entry keeps the last two outcomes resolved against it. It predicts not taken only when both are not taken.
- R9: When a prediction and a resolve use the same entry in one cycle, the prediction reflects the entry's state before that resolve.
- R10: A resolve without the mispredict flag and without a prediction request leaves the history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_req | input | 1 | Prediction requested this cycle |
| pred_taken | output | 1 | Predicted direction for the current history (1 = taken) |
| pred_snap | output | HIST_W | Current history register, to be returned at resolve |
| res_valid | input | 1 | A branch resolves this cycle |
| res_taken | input | 1 | Real outcome of the resolving branch |
| res_mispred | input | 1 | The resolving branch was mispredicted |
| res_snap | input | HIST_W | History copy that came with the resolving prediction |

## Verification
The history register is visible on pred_snap in every cycle. A wrong shift, a dropped repair or a lost priority therefore shows up one edge after the faulty cycle.

A corrupted table entry shows up only when the history next selects that entry. So every table index is resolved repeatedly in each direction, and the history is then steered back onto those indices through repairs. The bench models all three automata side by side, so a mode-specific update error changes pred_taken within a few visits.

// File: rtl/glob_dir_predictor.sv
`timescale 1ns/1ps
module glob_dir_predictor #(
  parameter int HIST_W = 4,
  parameter int KIND   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_req,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_snap,
  input  logic              res_valid,
  input  logic              res_taken,
  input  logic              res_mispred,
  input  logic [HIST_W-1:0] res_snap
);
  localparam int         ENTRIES = 1 << HIST_W;
  localparam logic [1:0] INIT    = (KIND == 0) ? 2'd1 : 2'd3;

  logic [HIST_W-1:0] ghr;
  logic [1:0]        pht [ENTRIES];
  logic [1:0]        cur, old, upd;
  logic              repair;

  assign cur       = pht[ghr];
  assign old       = pht[res_snap];
  assign repair    = res_valid & res_mispred;
  assign pred_snap = ghr;

  generate
    if (KIND == 0) begin : g_last
      assign pred_taken = cur[0];
      assign upd        = {1'b0, res_taken};
    end else if (KIND == 1) begin : g_pair
      assign pred_taken = |cur;
      assign upd        = {old[0], res_taken};
    end else begin : g_ctr
      assign pred_taken = cur[1];
      assign upd = res_taken ? ((old == 2'd3) ? old : old + 2'd1)
                             : ((old == 2'd0) ? old : old - 2'd1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)        ghr <= '0;
    else if (repair)   ghr <= {res_snap[HIST_W-2:0], res_taken};
    else if (pred_req) ghr <= {ghr[HIST_W-2:0], pred_taken};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) pht[i] <= INIT;
    end else if (res_valid) begin
      pht[res_snap] <= upd;
    end
  end

  // R2
  spec_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_req && !(res_valid && res_mispred)) |=>
      pred_snap == {$past(pred_snap[HIST_W-2:0]), $past(pred_taken)});

  // R3
  repair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_mispred) |=>
      pred_snap == {$past(res_snap[HIST_W-2:0]), $past(res_taken)});

  // R10
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pred_req && !(res_valid && res_mispred)) |=> $stable(pred_snap));

  // R5
  idle_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && !pred_req && !res_mispred) |=> $stable(pred_taken));

  generate
    if (KIND == 2) begin : g_ctr_chk
      // R6
      sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken && pht[res_snap] == 2'd3) |=>
          pht[$past(res_snap)] == 2'd3);
      // R6
      sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken && pht[res_snap] == 2'd0) |=>
          pht[$past(res_snap)] == 2'd0);
    end
  endgenerate
endmodule

// File: tb/tb_glob_dir_predictor.sv
`timescale 1ns/1ps
module tb_glob_dir_predictor;
  localparam int HW = 3;
  localparam int N  = 1 << HW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, pred_req, res_valid, res_taken, res_mispred;
  logic [HW-1:0] res_snap;
  logic          pt0, pt1, pt2;
  logic [HW-1:0] ps0, ps1, ps2;

  glob_dir_predictor #(.HIST_W(HW), .KIND(0)) dut_last (
    .clk(clk), .rst_n(rst_n), .pred_req(pred_req), .pred_taken(pt0), .pred_snap(ps0),
    .res_valid(res_valid), .res_taken(res_taken), .res_mispred(res_mispred), .res_snap(res_snap));
  glob_dir_predictor #(.HIST_W(HW), .KIND(1)) dut_pair (
    .clk(clk), .rst_n(rst_n), .pred_req(pred_req), .pred_taken(pt1), .pred_snap(ps1),
    .res_valid(res_valid), .res_taken(res_taken), .res_mispred(res_mispred), .res_snap(res_snap));
  glob_dir_predictor #(.HIST_W(HW), .KIND(2)) dut (
    .clk(clk), .rst_n(rst_n), .pred_req(pred_req), .pred_taken(pt2), .pred_snap(ps2),
    .res_valid(res_valid), .res_taken(res_taken), .res_mispred(res_mispred), .res_snap(res_snap));

  int checks = 0;
  int fails  = 0;
  logic [1:0]    m_pht [3][N];
  logic [HW-1:0] m_ghr [3];
  logic [15:0]   lfsr = 16'hACE1;

  function automatic logic m_pred(int k, logic [1:0] s);
    if (k == 0) return s[0];
    if (k == 1) return s[0] | s[1];
    return s[1];
  endfunction

  function automatic logic [1:0] m_next(int k, logic [1:0] s, logic t);
    if (k == 0) return {1'b0, t};
    if (k == 1) return {s[0], t};
    if (t) return (s == 2'd3) ? 2'd3 : s + 2'd1;
    return (s == 2'd0) ? 2'd0 : s - 2'd1;
  endfunction

  task automatic check(input logic [HW-1:0] act, input logic [HW-1:0] exp,
                       input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string htag, input logic rv, input logic [HW-1:0] rs);
    for (int k = 0; k < 3; k++) begin
      logic          p;
      logic [HW-1:0] s;
      string         ptag;
      p = (k == 0) ? pt0 : (k == 1) ? pt1 : pt2;
      s = (k == 0) ? ps0 : (k == 1) ? ps1 : ps2;
      ptag = (rv && rs == m_ghr[k]) ? "R9" : (k == 0) ? "R7" : (k == 1) ? "R8" : "R6";
      check({{(HW-1){1'b0}}, p}, {{(HW-1){1'b0}}, m_pred(k, m_pht[k][m_ghr[k]])},
            ptag, $sformatf("prediction kind %0d", k));
      check(s, m_ghr[k], htag, $sformatf("history kind %0d", k));
    end
  endtask

  task automatic step(input logic pr, input logic rv, input logic rt,
                      input logic rm, input logic [HW-1:0] rs, input string htag);
    @(negedge clk);
    pred_req = pr; res_valid = rv; res_taken = rt; res_mispred = rm; res_snap = rs;
    #1;
    compare_all(htag, rv, rs);
    for (int k = 0; k < 3; k++) begin
      logic pk;
      pk = m_pred(k, m_pht[k][m_ghr[k]]);
      if (rv) m_pht[k][rs] = m_next(k, m_pht[k][rs], rt);
      if (rv && rm)  m_ghr[k] = {rs[HW-2:0], rt};
      else if (pr)   m_ghr[k] = {m_ghr[k][HW-2:0], pk};
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; pred_req = 1'b0; res_valid = 1'b0; res_taken = 1'b0;
    res_mispred = 1'b0; res_snap = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      m_ghr[k] = '0;
      for (int i = 0; i < N; i++) m_pht[k][i] = (k == 0) ? 2'd1 : 2'd3;
    end
    #1;
    compare_all("R1", 1'b0, '0);

    // R5: train entry 5 down, entry 0 (current history) must stay taken
    step(1'b0, 1'b1, 1'b0, 1'b0, 3'd5, "R10");
    step(1'b0, 1'b1, 1'b0, 1'b0, 3'd5, "R10");
    step(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, "R5");
    // R3: repair to snapshot 2 with taken -> history 5
    step(1'b0, 1'b1, 1'b1, 1'b1, 3'd2, "R3");
    step(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, "R3");
    // R4: repair and request together
    step(1'b1, 1'b1, 1'b0, 1'b1, 3'd6, "R4");
    step(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, "R4");
    // R2: speculative shifts
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, "R2");

    // sweep: every entry, both directions, saturating runs, revisited by repair
    for (int e = 0; e < N; e++)
      for (int t = 0; t < 2; t++) begin
        for (int r = 0; r < 4; r++) step(1'b0, 1'b1, t[0], 1'b0, e[HW-1:0], "R10");
        step(1'b0, 1'b1, t[0], 1'b1, e[HW-1:0], "R3");
        step(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, "R2");
      end

    // R9: resolve the entry the current history selects
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 1'b1, i[0] ^ i[2], 1'b0, m_ghr[2], "R2");
    end

    // pseudo-random mix
    for (int i = 0; i < 3000; i++) begin
      logic pr, rv, rm;
      string ht;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pr = lfsr[0]; rv = lfsr[1] | lfsr[2]; rm = lfsr[3] & lfsr[4];
      ht = (rv && rm && pr) ? "R4" : (rv && rm) ? "R3" : pr ? "R2" : "R10";
      step(pr, rv, lfsr[5], rm, lfsr[9:7], ht);
    end

    step(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, "R10");
    summary();
    $finish;
  end
endmodule